// File: doc/BRIEF.md
# Draw Cost Tick Accumulator

This block estimates how many rendering ticks a drawing primitive will take and keeps a running total of work that is still outstanding. Each time a primitive is issued, the front end presents its kind, its bounding-box width and height, and the attribute flags that make pixels more expensive: texturing, semi-transparent blending, mask testing and interlaced rendering. It raises a one-cycle strobe. The block turns these into a tick cost and adds it to a pending counter.

Every cycle, the pending counter also drops by the number of ticks that elapsed in that cycle. A scheduler reads the pending count and the busy flag to decide when the drawing engine will be free. The estimate is coarse by design. A triangle is charged as if every row were one third of its box wide. A rectangle is charged for the full width of every row. A line is charged for its longer side.

An optional register stage between the estimator and the counter, chosen by a parameter, shortens the combinational path from the primitive inputs to the counter. It costs one extra cycle of latency.

Top module: `draw_cost_accum`

## Requirements
- R1: After reset, `pending` is 0 and `busy` is 0.
- R2: A triangle (`prim` = 0) has a base cost per row of floor((width+2)/3). Its total cost is the per-row cost times the effective height.
- R3: A rectangle (`prim` = 1) has a base cost per row equal to its width. Its total cost is the per-row cost times the effective height.
- R4: For triangles and rectangles, `textured` = 1 adds the base cost a second time to each row.
- R5: For triangles and rectangles, `semi_trans` = 1 or `mask_check` = 1 adds floor((base+1)/2) to each row. The surcharge is added once, even when both flags are set.
- R6: A line (`prim` = 2) costs the larger of its width and its effective height. `textured`, `semi_trans` and `mask_check` have no effect on a line.
- R7: With `interlaced` = 1, the effective height is floor(height/2), raised to 1 if that is 0. With `interlaced` = 0, the effective height is the height.
- R8: A strobe with `prim` = 3 (reserved) adds nothing to `pending`.
- R9: When the elapsed ticks reach or exceed the pending work, `pending` becomes 0. It never wraps below zero.
- R10: `pending` saturates at its all-ones value instead of wrapping.
- R11: In a cycle that carries both a new cost and elapsed ticks, the new `pending` is the old value plus the cost minus the elapsed ticks, floored at 0 and capped at all-ones.
- R12: `busy` is 1 exactly when `pending` is nonzero.
- R13: The cost of a strobe reaches `pending` at the first clock edge after the strobe when COST_REG = 0, and at the second edge when COST_REG = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cost_valid | input | 1 | One-cycle strobe: a primitive is issued this cycle |
| prim | input | 2 | Primitive kind: 0 triangle, 1 rectangle, 2 line, 3 reserved |
| width | input | DIM_W | Bounding-box width in pixels |
| height | input | DIM_W | Bounding-box height in pixels |
| textured | input | 1 | Primitive is textured |
| semi_trans | input | 1 | Primitive is semi-transparent |
| mask_check | input | 1 | Mask test is enabled for the primitive |
| interlaced | input | 1 | Interlaced rendering is active |
| elapsed | input | TICK_W | Ticks consumed in this cycle |
| pending | output | CNT_W | Outstanding tick count |
| busy | output | 1 | Outstanding work is nonzero |

## Verification
The bench builds the block with CNT_W = 16, TICK_W = 12 and COST_REG = 1.

A 16-bit counter lets a single large textured rectangle reach the all-ones ceiling. A 12-bit elapsed input can drain a full counter in a few cycles. Together, these put both saturation limits within reach of short directed sequences. The registered variant covers the extra pipeline stage, including a cost that is still in flight while the counter drains.

Random primitives of every kind, mixing small and full-range dimensions with random flags, cover the rounding of the divide-by-three and the halving of odd heights.

// File: rtl/draw_cost_pkg.sv
package draw_cost_pkg;

    typedef enum logic [1:0] {
        PRIM_TRI  = 2'd0,
        PRIM_RECT = 2'd1,
        PRIM_LINE = 2'd2,
        PRIM_RSVD = 2'd3
    } prim_kind_e;

endpackage

// File: rtl/draw_cost_height.sv
// Effective row count: halved (min 1) while interlaced rendering is on.
module draw_cost_height #(
    parameter int DIM_W = 11
) (
    input  logic [DIM_W-1:0] height,
    input  logic             interlaced,
    output logic [DIM_W-1:0] rows_eff
);
    logic [DIM_W-1:0] half_d;

    always_comb begin
        half_d = height >> 1;
        if (!interlaced) begin
            rows_eff = height;
        end else if (half_d == '0) begin
            rows_eff = DIM_W'(1);
        end else begin
            rows_eff = half_d;
        end
    end
endmodule

// File: rtl/draw_cost_row.sv
// Per-row charge and row multiplier for each primitive kind.
module draw_cost_row
    import draw_cost_pkg::*;
#(
    parameter int DIM_W = 11,
    parameter int ROW_W = DIM_W + 2
) (
    input  prim_kind_e       kind,
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] rows_eff,
    input  logic             textured,
    input  logic             blend,
    output logic [ROW_W-1:0] row_cost,
    output logic [DIM_W-1:0] row_mult
);
    localparam int EXT_W = DIM_W + 1;

    logic [EXT_W-1:0] tri_base_d;
    logic [ROW_W-1:0] base_d;
    logic [ROW_W-1:0] half_d;

    always_comb begin
        tri_base_d = (EXT_W'(width) + EXT_W'(2)) / EXT_W'(3);
        base_d     = '0;
        row_cost   = '0;
        row_mult   = '0;
        half_d     = '0;
        unique case (kind)
            PRIM_TRI, PRIM_RECT: begin
                base_d   = (kind == PRIM_TRI) ? ROW_W'(tri_base_d) : ROW_W'(width);
                half_d   = (base_d + ROW_W'(1)) >> 1;
                row_cost = base_d
                         + (textured ? base_d : '0)
                         + (blend ? half_d : '0);
                row_mult = rows_eff;
            end
            PRIM_LINE: begin
                row_cost = (width > rows_eff) ? ROW_W'(width) : ROW_W'(rows_eff);
                row_mult = DIM_W'(1);
            end
            default: begin
                row_cost = '0;
                row_mult = '0;
            end
        endcase
    end
endmodule

// File: rtl/draw_cost_acc.sv
// Pending tick counter: add cost, subtract elapsed, clamp to [0, all-ones].
module draw_cost_acc #(
    parameter int CNT_W  = 32,
    parameter int COST_W = 24,
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_valid,
    input  logic [COST_W-1:0] add_cost,
    input  logic [TICK_W-1:0] elapsed,
    output logic [CNT_W-1:0]  pending,
    output logic              busy
);
    localparam int BIG_W = (CNT_W > COST_W) ? CNT_W : COST_W;
    localparam int SUM_W = ((BIG_W > TICK_W) ? BIG_W : TICK_W) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] pend;
        logic             busy;
    } acc_t;

    acc_t st_d, st_q;
    logic [SUM_W-1:0] sum_d, left_d, ceil_d;

    always_comb begin
        ceil_d = SUM_W'({CNT_W{1'b1}});
        sum_d  = SUM_W'(st_q.pend) + (add_valid ? SUM_W'(add_cost) : '0);
        if (sum_d <= SUM_W'(elapsed)) begin
            left_d = '0;
        end else begin
            left_d = sum_d - SUM_W'(elapsed);
        end
        st_d.pend = (left_d > ceil_d) ? {CNT_W{1'b1}} : CNT_W'(left_d);
        st_d.busy = (st_d.pend != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pend;
    assign busy    = st_q.busy;
endmodule

// File: rtl/draw_cost_accum.sv
module draw_cost_accum
    import draw_cost_pkg::*;
#(
    parameter int DIM_W    = 11,
    parameter int CNT_W    = 32,
    parameter int TICK_W   = 8,
    parameter bit COST_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cost_valid,
    input  logic [1:0]        prim,
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  height,
    input  logic              textured,
    input  logic              semi_trans,
    input  logic              mask_check,
    input  logic              interlaced,
    input  logic [TICK_W-1:0] elapsed,
    output logic [CNT_W-1:0]  pending,
    output logic              busy
);
    localparam int ROW_W  = DIM_W + 2;
    localparam int COST_W = ROW_W + DIM_W;

    prim_kind_e        kind;
    logic [DIM_W-1:0]  rows_eff;
    logic [ROW_W-1:0]  row_cost;
    logic [DIM_W-1:0]  row_mult;
    logic [COST_W-1:0] est_cost;
    logic              add_valid;
    logic [COST_W-1:0] add_cost;

    assign kind = prim_kind_e'(prim);

    draw_cost_height #(.DIM_W(DIM_W)) u_height (
        .height     (height),
        .interlaced (interlaced),
        .rows_eff   (rows_eff)
    );

    draw_cost_row #(.DIM_W(DIM_W), .ROW_W(ROW_W)) u_row (
        .kind     (kind),
        .width    (width),
        .rows_eff (rows_eff),
        .textured (textured),
        .blend    (semi_trans | mask_check),
        .row_cost (row_cost),
        .row_mult (row_mult)
    );

    assign est_cost = COST_W'(row_cost) * COST_W'(row_mult);

    generate
        if (COST_REG) begin : g_stage
            typedef struct packed {
                logic              vld;
                logic [COST_W-1:0] cost;
            } stage_t;
            stage_t stg_d, stg_q;

            always_comb begin
                stg_d.vld  = cost_valid;
                stg_d.cost = cost_valid ? est_cost : '0;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_q <= '0;
                end else begin
                    stg_q <= stg_d;
                end
            end

            assign add_valid = stg_q.vld;
            assign add_cost  = stg_q.cost;
        end else begin : g_direct
            assign add_valid = cost_valid;
            assign add_cost  = est_cost;
        end
    endgenerate

    draw_cost_acc #(.CNT_W(CNT_W), .COST_W(COST_W), .TICK_W(TICK_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .add_valid (add_valid),
        .add_cost  (add_cost),
        .elapsed   (elapsed),
        .pending   (pending),
        .busy      (busy)
    );
endmodule

// File: rtl/draw_cost_accum_chk.sv
module draw_cost_accum_chk #(
    parameter int DIM_W  = 11,
    parameter int CNT_W  = 32,
    parameter int TICK_W = 8,
    parameter int COST_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        prim,
    input logic [DIM_W-1:0]  width,
    input logic [DIM_W-1:0]  height,
    input logic              interlaced,
    input logic [TICK_W-1:0] elapsed,
    input logic              add_valid,
    input logic [COST_W-1:0] est_cost,
    input logic [CNT_W-1:0]  pending,
    input logic              busy
);
    assert_busy_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (pending != '0));

    assert_drain_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_valid && 64'(elapsed) >= 64'(pending)) |=> pending == '0);

    assert_drain_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_valid && 64'(elapsed) < 64'(pending))
        |=> 64'(pending) == $past(64'(pending)) - $past(64'(elapsed)));

    assert_no_shrink_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (add_valid && elapsed == '0) |=> pending >= $past(pending));

    assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prim == 2'd3) |-> est_cost == '0);

    assert_line_cost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prim == 2'd2 && !interlaced)
        |-> 64'(est_cost) == ((width > height) ? 64'(width) : 64'(height)));
endmodule

bind draw_cost_accum draw_cost_accum_chk #(
    .DIM_W(DIM_W), .CNT_W(CNT_W), .TICK_W(TICK_W), .COST_W(COST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prim       (prim),
    .width      (width),
    .height     (height),
    .interlaced (interlaced),
    .elapsed    (elapsed),
    .add_valid  (add_valid),
    .est_cost   (est_cost),
    .pending    (pending),
    .busy       (busy)
);

// File: tb/draw_cost_accum_tb_top.sv
module draw_cost_accum_tb_top;
    localparam int  DIM_W  = 11;
    localparam int  CNT_W  = 16;
    localparam int  TICK_W = 12;
    localparam bit  CREG   = 1'b1;
    localparam longint CMAX = (64'd1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cost_valid = 1'b0;
    logic [1:0]        prim = '0;
    logic [DIM_W-1:0]  width = '0;
    logic [DIM_W-1:0]  height = '0;
    logic              textured = 1'b0;
    logic              semi_trans = 1'b0;
    logic              mask_check = 1'b0;
    logic              interlaced = 1'b0;
    logic [TICK_W-1:0] elapsed = '0;
    logic [CNT_W-1:0]  pending;
    logic              busy;

    int     n_vec = 0;
    int     n_bad = 0;
    bit     done  = 1'b0;
    longint m_pend = 0;
    longint m_stage = 0;

    always #10ns clk = ~clk;

    draw_cost_accum #(
        .DIM_W(DIM_W), .CNT_W(CNT_W), .TICK_W(TICK_W), .COST_REG(CREG)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cost_valid(cost_valid), .prim(prim),
        .width(width), .height(height), .textured(textured),
        .semi_trans(semi_trans), .mask_check(mask_check),
        .interlaced(interlaced), .elapsed(elapsed),
        .pending(pending), .busy(busy)
    );

    function automatic longint exp_cost(int p, int w, int h, bit tx, bit st, bit mk, bit il);
        longint he, base, row;
        he = il ? ((h / 2) < 1 ? 1 : h / 2) : h;
        if (p == 3) return 0;
        if (p == 2) return (w > he) ? w : he;
        base = (p == 0) ? (w + 2) / 3 : w;
        row  = base;
        if (tx) row += base;
        if (st || mk) row += (base + 1) / 2;
        return row * he;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(string tag, int p, int w, int h, bit tx, bit st, bit mk,
                        bit il, bit v, int el);
        longint c, add, s;
        cost_valid = v; prim = 2'(p); width = DIM_W'(w); height = DIM_W'(h);
        textured = tx; semi_trans = st; mask_check = mk; interlaced = il;
        elapsed = TICK_W'(el);
        @(posedge clk);
        #1;
        c   = v ? exp_cost(p, w, h, tx, st, mk, il) : 0;
        add = CREG ? m_stage : c;
        s   = m_pend + add;
        s   = (s <= el) ? 0 : s - el;
        m_pend  = (s > CMAX) ? CMAX : s;
        m_stage = c;
        @(negedge clk);
        chk(tag, longint'(pending), m_pend);
        chk("R12", longint'(busy), (m_pend != 0) ? 1 : 0);
    endtask

    task automatic idle(string tag, int el);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, el);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", longint'(pending), 0);
        chk("R1", longint'(busy), 0);

        // R2 triangle 10x4 -> 4*4, R13 arrives after the stage
        step("R2", 0, 10, 4, 0, 0, 0, 0, 1, 0);
        chk("R13", longint'(pending), 0);
        idle("R13", 0);
        idle("R9", 4000);
        step("R2", 0, 11, 5, 0, 0, 0, 0, 1, 0);
        idle("R2", 0);
        idle("R9", 4000);
        // R3 rectangle 7x3
        step("R3", 1, 7, 3, 0, 0, 0, 0, 1, 0);
        idle("R3", 0);
        idle("R9", 4000);
        // R4 texture
        step("R4", 1, 7, 3, 1, 0, 0, 0, 1, 0);
        idle("R4", 0);
        idle("R9", 4000);
        step("R4", 0, 13, 2, 1, 0, 0, 0, 1, 0);
        idle("R4", 0);
        idle("R9", 4000);
        // R5 blend / mask surcharge, once for both
        step("R5", 1, 7, 3, 0, 1, 0, 0, 1, 0);
        idle("R5", 0);
        step("R5", 1, 7, 3, 0, 0, 1, 0, 1, 0);
        idle("R5", 0);
        step("R5", 0, 9, 2, 1, 1, 1, 0, 1, 0);
        idle("R5", 0);
        idle("R9", 4000);
        // R6 lines ignore texture and blend
        step("R6", 2, 5, 9, 1, 1, 1, 0, 1, 0);
        idle("R6", 0);
        step("R6", 2, 30, 2, 0, 1, 0, 0, 1, 0);
        idle("R6", 0);
        idle("R9", 4000);
        // R7 interlaced halving
        step("R7", 1, 6, 1, 0, 0, 0, 1, 1, 0);
        idle("R7", 0);
        step("R7", 1, 6, 9, 0, 0, 0, 1, 1, 0);
        idle("R7", 0);
        step("R7", 1, 6, 0, 0, 0, 0, 1, 1, 0);
        idle("R7", 0);
        step("R7", 2, 1, 40, 0, 0, 0, 1, 1, 0);
        idle("R7", 0);
        // R8 reserved kind adds nothing
        step("R8", 3, 500, 500, 1, 1, 1, 0, 1, 0);
        idle("R8", 0);
        // R9 partial drain then floor
        idle("R9", 3);
        idle("R9", 4000);
        // R10 saturation high
        step("R10", 1, 2047, 2047, 1, 1, 0, 0, 1, 0);
        idle("R10", 0);
        step("R10", 1, 100, 100, 0, 0, 0, 0, 1, 0);
        idle("R10", 5);
        // R11 add and drain together
        repeat (20) idle("R9", 4095);
        step("R11", 1, 50, 10, 0, 0, 0, 0, 1, 0);
        step("R11", 1, 20, 10, 0, 0, 0, 0, 1, 100);
        idle("R11", 30);
        idle("R11", 1000);

        for (int i = 0; i < 3000; i++) begin
            int p, w, h, el;
            p  = int'($urandom_range(0, 3));
            w  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 2047))
                                             : int'($urandom_range(0, 40));
            h  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 2047))
                                             : int'($urandom_range(0, 40));
            el = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 300))
                                             : int'($urandom_range(0, 4095));
            step("R11", p, w, h, 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), el);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule